// File: doc/BRIEF.md
# Coprocessor Conditional Trap Sequencer

This block runs a coprocessor-evaluated conditional trap on the main-processor side. It first accepts the operation word from an instruction word stream, then the selector word that follows it. It checks that the instruction is well formed. It then writes the selector word to the coprocessor's condition register and reads the coprocessor's response register once per cycle until the coprocessor returns a verdict.

A true verdict raises a one-cycle trap request. A false verdict lets execution continue. In both cases the block pulses `done` and gives a skip count. The instruction-fetch side uses that count to step over the words that trail the selector: the coprocessor-defined extension words first, then the operand words. The operand word count comes from the low three bits of the operation word. The extension word count is a configuration input. The block does not consume these trailing words itself.

Top module: `cotrap_seq`

## Requirements
- R1: After a synchronous active-high reset, including one applied in the middle of polling, the block is idle. `iw_ready` is 1. `cp_wr`, `cp_rd`, `done`, `trap_req`, `illegal_instr` and `proto_err` are all 0.
- R2: The first word accepted through `iw_valid`/`iw_ready` is the operation word and the second is the selector word. `iw_ready` stays 0 from the cycle after the selector is accepted until the instruction terminates.
- R3: In the cycle after the selector word is accepted, the block issues exactly one write with `cp_sel`=0 (condition register). `cp_wdata` carries the whole 16-bit selector word.
- R4: The instruction is illegal when selector bits 15:6 are not all zero, or when operation-word bits 2:0 are not 010, 011 or 100. In that case `illegal_instr` pulses for one cycle, in the cycle after the selector is accepted. No coprocessor write or read is issued, and the block returns to idle.
- R5: After the write, the block reads with `cp_sel`=1 (response register) in every cycle. A response of 16'h0000 means busy and polling continues.
- R6: A response of 16'h0001 (false) makes `done` pulse for one cycle, in the cycle after the read that returned it, with `trap_req` at 0.
- R7: A response of 16'h0002 (true) makes `done` and `trap_req` pulse together for one cycle, in the cycle after that read.
- R8: With `done`, `skip_cnt` equals the extension word count plus the operand word count. `ext_words` is sampled when the selector is accepted. The operand word count is 1 for opmode 010, 2 for 011 and 0 for 100.
- R9: Any response other than 0000, 0001 or 0002 makes `proto_err` pulse for one cycle after that read, with no `done`.
- R10: If POLL_LIMIT consecutive reads return busy, `proto_err` pulses after the last of them, with no `done`. A verdict returned on the read that follows POLL_LIMIT-1 busy reads is honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_words | input | 2 | Number of coprocessor-defined extension words (0..3) |
| iw_valid | input | 1 | Instruction word valid |
| iw_data | input | 16 | Instruction word |
| iw_ready | output | 1 | Sequencer can accept an instruction word |
| cp_sel | output | 1 | Coprocessor register select: 0 condition, 1 response |
| cp_wr | output | 1 | Coprocessor register write strobe |
| cp_rd | output | 1 | Coprocessor register read strobe |
| cp_wdata | output | 16 | Write data to the coprocessor |
| cp_rdata | input | 16 | Read data from the coprocessor, valid while `cp_rd` is 1 |
| done | output | 1 | Instruction finished with a verdict |
| trap_req | output | 1 | True verdict: start trap processing |
| skip_cnt | output | 3 | Words to skip, valid with `done` |
| illegal_instr | output | 1 | Malformed instruction detected |
| proto_err | output | 1 | Bad response or poll timeout |

## Verification
A verdict can arrive on the very read where the poll timer has reached its last permitted busy step, so the answer path and the timeout path compete in the same cycle. The bench sets up that case by letting its coprocessor model answer busy exactly POLL_LIMIT-1 times before answering false. It expects `done` with the correct skip count and no `proto_err`. A companion vector that stays busy one read longer must give `proto_err` in the cycle after the POLL_LIMIT-th busy read and no `done`.

// File: rtl/cotrap_pkg.sv
package cotrap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEL  = 2'd1,
    ST_WR   = 2'd2,
    ST_POLL = 2'd3
  } seq_state_t;

  localparam logic [15:0] RSP_BUSY  = 16'h0000;
  localparam logic [15:0] RSP_FALSE = 16'h0001;
  localparam logic [15:0] RSP_TRUE  = 16'h0002;

  // Opmode (low opcode bits) legality
  function automatic logic opmode_ok(input logic [2:0] m);
    return (m == 3'b010) || (m == 3'b011) || (m == 3'b100);
  endfunction

  // Trailing operand word count for a legal opmode
  function automatic logic [2:0] operand_words(input logic [2:0] m);
    case (m)
      3'b010:  return 3'd1;
      3'b011:  return 3'd2;
      default: return 3'd0;
    endcase
  endfunction

  // Total words to step over after the selector
  function automatic logic [2:0] skip_words(input logic [1:0] ext, input logic [2:0] m);
    return {1'b0, ext} + operand_words(m);
  endfunction

endpackage

// File: rtl/cotrap_decode.sv
module cotrap_decode
  import cotrap_pkg::*;
(
  input  logic [2:0]  opmode,
  input  logic [15:0] selector,
  input  logic [1:0]  ext,
  output logic        bad,
  output logic [2:0]  skip
);

  logic rsv_nonzero;

  always_comb begin
    rsv_nonzero = |selector[15:6];
    bad         = rsv_nonzero || !opmode_ok(opmode);
    skip        = skip_words(ext, opmode);
  end

  // R8: a legal instruction never asks to skip more than ext + 2 words
  always_comb begin
    if (!bad) begin
      skip_range_chk: assert (skip <= 3'd5 && skip >= {1'b0, ext});
    end
  end

endmodule

// File: rtl/cotrap_poll_timer.sv
module cotrap_poll_timer #(
  parameter int POLL_LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic expire
);

  localparam int CW = $clog2(POLL_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(POLL_LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expire = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (tick && !expire) cnt <= cnt + 1'b1;
  end

  // R10: a cleared timer starts the next poll window from zero
  timer_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt == '0));

  // R10: the counter never runs past its last step
  timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

endmodule

// File: rtl/cotrap_seq.sv
module cotrap_seq
  import cotrap_pkg::*;
#(
  parameter int POLL_LIMIT = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  ext_words,
  input  logic        iw_valid,
  input  logic [15:0] iw_data,
  output logic        iw_ready,
  output logic        cp_sel,
  output logic        cp_wr,
  output logic        cp_rd,
  output logic [15:0] cp_wdata,
  input  logic [15:0] cp_rdata,
  output logic        done,
  output logic        trap_req,
  output logic [2:0]  skip_cnt,
  output logic        illegal_instr,
  output logic        proto_err
);

  seq_state_t  state;
  logic [2:0]  opmode_q;
  logic [15:0] sel_q;
  logic [2:0]  skip_q;

  logic        dec_bad;
  logic [2:0]  dec_skip;
  logic        tmr_expire;

  // Named internal events
  logic ev_op_take, ev_sel_take, ev_bad, ev_busy, ev_false, ev_true, ev_junk, ev_timeout;

  cotrap_decode u_dec (
    .opmode   (opmode_q),
    .selector (iw_data),
    .ext      (ext_words),
    .bad      (dec_bad),
    .skip     (dec_skip)
  );

  cotrap_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .clear  (cp_wr),
    .tick   (ev_busy),
    .expire (tmr_expire)
  );

  always_comb begin
    iw_ready    = (state == ST_IDLE) || (state == ST_SEL);
    cp_wr       = (state == ST_WR);
    cp_rd       = (state == ST_POLL);
    cp_sel      = (state == ST_POLL);
    cp_wdata    = sel_q;
    ev_op_take  = (state == ST_IDLE) && iw_valid;
    ev_sel_take = (state == ST_SEL) && iw_valid;
    ev_bad      = ev_sel_take && dec_bad;
    ev_busy     = cp_rd && (cp_rdata == RSP_BUSY);
    ev_false    = cp_rd && (cp_rdata == RSP_FALSE);
    ev_true     = cp_rd && (cp_rdata == RSP_TRUE);
    ev_junk     = cp_rd && !ev_busy && !ev_false && !ev_true;
    ev_timeout  = tmr_expire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      opmode_q <= '0;
      sel_q    <= '0;
      skip_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (ev_op_take) begin
          opmode_q <= iw_data[2:0];
          state    <= ST_SEL;
        end
        ST_SEL: if (ev_sel_take) begin
          sel_q  <= iw_data;
          skip_q <= dec_skip;
          state  <= dec_bad ? ST_IDLE : ST_WR;
        end
        ST_WR:   state <= ST_POLL;
        ST_POLL: if (!ev_busy || ev_timeout) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done          <= 1'b0;
      trap_req      <= 1'b0;
      skip_cnt      <= '0;
      illegal_instr <= 1'b0;
      proto_err     <= 1'b0;
    end else begin
      done          <= ev_false || ev_true;
      trap_req      <= ev_true;
      skip_cnt      <= (ev_false || ev_true) ? skip_q : 3'd0;
      illegal_instr <= ev_bad;
      proto_err     <= ev_junk || ev_timeout;
    end
  end

  // R3: every condition write is followed by a response read
  wr_then_rd_chk: assert property (@(posedge clk) disable iff (rst)
    cp_wr |=> (cp_rd && cp_sel));

  // R4: a malformed instruction never reaches the coprocessor
  illegal_nowr_chk: assert property (@(posedge clk) disable iff (rst)
    ev_bad |=> (illegal_instr && !cp_wr && !cp_rd));

  // R7: a trap request always comes with done
  trap_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> done);

  // R9: completion and protocol error are exclusive
  done_xor_err_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && proto_err));

  // R6: done only follows a response read
  done_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(cp_rd));

  // R2: no word is taken while the coprocessor is being polled
  no_fetch_in_poll_chk: assert property (@(posedge clk) disable iff (rst)
    cp_rd |-> !iw_ready);

  // R1: at most one terminal indication per cycle
  one_term_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, illegal_instr, proto_err}));

endmodule

// File: tb/sim_cotrap_seq.sv
module sim_cotrap_seq;

  localparam int LIMIT = 8;

  typedef struct packed {
    logic [15:0] op;
    logic [15:0] sel;
    logic [1:0]  ext;
    logic [4:0]  busy;
    logic [15:0] resp;
    logic [1:0]  kind;   // 0 false, 1 true, 2 illegal, 3 protocol error
    logic [2:0]  skip;
    logic [1:0]  gap;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{16'hF07A, 16'h0005, 2'd0, 5'd0,  16'h0001, 2'd0, 3'd1, 2'd0},
    '{16'hF07B, 16'h003F, 2'd1, 5'd2,  16'h0002, 2'd1, 3'd3, 2'd1},
    '{16'hF07C, 16'h0000, 2'd3, 5'd0,  16'h0002, 2'd1, 3'd3, 2'd0},
    '{16'hF07C, 16'h0011, 2'd0, 5'd1,  16'h0001, 2'd0, 3'd0, 2'd2},
    '{16'hF07B, 16'h0021, 2'd3, 5'd7,  16'h0001, 2'd0, 3'd5, 2'd0},
    '{16'hF07A, 16'h0040, 2'd0, 5'd0,  16'h0001, 2'd2, 3'd0, 2'd0},
    '{16'hF07D, 16'h0001, 2'd0, 5'd0,  16'h0001, 2'd2, 3'd0, 2'd1},
    '{16'hF079, 16'h0002, 2'd2, 5'd0,  16'h0002, 2'd2, 3'd0, 2'd0},
    '{16'hF07A, 16'h0003, 2'd1, 5'd8,  16'h0001, 2'd3, 3'd0, 2'd0},
    '{16'hF07B, 16'h0004, 2'd0, 5'd3,  16'h0003, 2'd3, 3'd0, 2'd0},
    '{16'hF07C, 16'h8012, 2'd0, 5'd0,  16'h0001, 2'd2, 3'd0, 2'd0},
    '{16'hF07A, 16'h0007, 2'd2, 5'd0,  16'hFFFF, 2'd3, 3'd0, 2'd3}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ext_words = '0;
  logic        iw_valid = 1'b0;
  logic [15:0] iw_data = '0;
  logic        iw_ready, cp_sel, cp_wr, cp_rd;
  logic [15:0] cp_wdata, cp_rdata;
  logic        done, trap_req, illegal_instr, proto_err;
  logic [2:0]  skip_cnt;

  // Coprocessor model settings and monitor
  logic        mon_clr = 1'b0;
  int          busy_n = 0;
  logic [15:0] final_resp = 16'h0001;
  int          poll_n, wr_n, rd_bad_sel, wr_bad_sel;
  logic [15:0] wr_last;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cotrap_seq #(.POLL_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst(rst), .ext_words(ext_words),
    .iw_valid(iw_valid), .iw_data(iw_data), .iw_ready(iw_ready),
    .cp_sel(cp_sel), .cp_wr(cp_wr), .cp_rd(cp_rd),
    .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
    .done(done), .trap_req(trap_req), .skip_cnt(skip_cnt),
    .illegal_instr(illegal_instr), .proto_err(proto_err)
  );

  assign cp_rdata = (poll_n < busy_n) ? 16'h0000 : final_resp;

  always @(posedge clk) begin
    if (mon_clr) begin
      poll_n <= 0; wr_n <= 0; rd_bad_sel <= 0; wr_bad_sel <= 0; wr_last <= '0;
    end else begin
      if (cp_rd) begin
        poll_n <= poll_n + 1;
        if (cp_sel !== 1'b1) rd_bad_sel <= rd_bad_sel + 1;
      end
      if (cp_wr) begin
        wr_n    <= wr_n + 1;
        wr_last <= cp_wdata;
        if (cp_sel !== 1'b0) wr_bad_sel <= wr_bad_sel + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int exp_at, exp_rd, first_at, done_w, trap_w, ill_w, err_w, skip_seen, ready_poll;
    bit trap_at_first;
    busy_n = int'(v.busy); final_resp = v.resp;
    clear_mon();
    iw_valid = 1'b1; iw_data = v.op;
    @(negedge clk);
    iw_valid = 1'b0;
    repeat (int'(v.gap)) @(negedge clk);
    iw_valid = 1'b1; iw_data = v.sel; ext_words = v.ext;
    chk(iw_ready === 1'b1, "R2", "ready for selector", int'(iw_ready), 1);
    @(posedge clk);
    if (v.kind == 2'd2)             begin exp_at = 1;         exp_rd = 0;     end
    else if (int'(v.busy) >= LIMIT) begin exp_at = 2 + LIMIT; exp_rd = LIMIT; end
    else                            begin exp_at = 3 + int'(v.busy); exp_rd = int'(v.busy) + 1; end
    first_at = 0; done_w = 0; trap_w = 0; ill_w = 0; err_w = 0; skip_seen = 0;
    ready_poll = 0; trap_at_first = 1'b0;
    for (int c = 1; c <= 30; c++) begin
      @(negedge clk);
      if (c == 1) begin iw_valid = 1'b0; ext_words = 2'd0; end
      if (cp_rd && iw_ready) ready_poll++;
      if ((done || illegal_instr || proto_err) && first_at == 0) begin
        first_at = c; trap_at_first = trap_req; skip_seen = int'(skip_cnt);
      end
      done_w += int'(done); trap_w += int'(trap_req);
      ill_w  += int'(illegal_instr); err_w += int'(proto_err);
    end
    chk(first_at == exp_at, "R6", "terminal cycle", first_at, exp_at);
    chk(ready_poll == 0, "R2", "ready while polling", ready_poll, 0);
    chk(poll_n == exp_rd, "R5", "response reads", poll_n, exp_rd);
    chk(rd_bad_sel == 0, "R5", "read select", rd_bad_sel, 0);
    case (v.kind)
      2'd0, 2'd1: begin
        chk(done_w == 1 && ill_w == 0 && err_w == 0, "R6", "done pulses", done_w, 1);
        chk(trap_w == int'(v.kind) && trap_at_first == v.kind[0], "R7", "trap pulses", trap_w, int'(v.kind));
        chk(skip_seen == int'(v.skip), "R8", "skip count", skip_seen, int'(v.skip));
        chk(wr_n == 1 && wr_bad_sel == 0, "R3", "condition writes", wr_n, 1);
        chk(wr_last == v.sel, "R3", "written selector", int'(wr_last), int'(v.sel));
        if (int'(v.busy) == LIMIT - 1)
          chk(err_w == 0, "R10", "verdict on last allowed read", err_w, 0);
      end
      2'd2: begin
        chk(ill_w == 1 && done_w == 0 && err_w == 0, "R4", "illegal pulses", ill_w, 1);
        chk(wr_n == 0, "R4", "writes on illegal", wr_n, 0);
      end
      default: begin
        if (int'(v.busy) >= LIMIT)
          chk(err_w == 1 && done_w == 0, "R10", "timeout error", err_w, 1);
        else
          chk(err_w == 1 && done_w == 0, "R9", "bad response error", err_w, 1);
        chk(trap_w == 0, "R9", "no trap on error", trap_w, 0);
      end
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(iw_ready === 1'b1, "R1", "iw_ready in reset", int'(iw_ready), 1);
    chk({cp_wr, cp_rd, done, trap_req, illegal_instr, proto_err} === 6'b0, "R1", "outputs in reset",
        int'({cp_wr, cp_rd, done, trap_req, illegal_instr, proto_err}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(iw_ready === 1'b1 && !cp_wr && !cp_rd, "R1", "idle after reset", int'(iw_ready), 1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R1: reset applied in the middle of polling
    busy_n = 25; final_resp = 16'h0001;
    clear_mon();
    iw_valid = 1'b1; iw_data = 16'hF07A;
    @(negedge clk);
    iw_data = 16'h0009;
    @(negedge clk);
    iw_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(cp_rd === 1'b1, "R5", "polling before reset", int'(cp_rd), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(iw_ready === 1'b1 && !cp_rd && !cp_wr, "R1", "idle after mid-poll reset", int'(cp_rd), 0);
    chk(!done && !proto_err && !trap_req, "R1", "no completion after reset", int'(done), 0);

    // Recovery: a true verdict with two extension words after the reset
    run_vec('{16'hF07B, 16'h0010, 2'd2, 5'd0, 16'h0002, 2'd1, 3'd4, 2'd0});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
    $finish;
  end

endmodule